// File: doc/BRIEF.md
# Extended-Precision Compare Condition Unit

This unit compares the value at the top of an eight-entry stack of 80-bit floating point registers with a second operand and reports the ordering. The second operand is another stack register addressed relative to the top, an 80-bit value supplied on a port, or the constant +0.0. The stack contents arrive on a flattened input bus. The unit itself owns the per-register empty flags and the 3-bit top pointer, because a compare can pop one or two entries from the stack.

The result goes to one of two places. In condition-code mode it is written into the condition field of a status word. In flag mode it is written into three processor-style flags, and the condition field is left as it was. Each compare selects ordered or unordered NaN handling. Invalid, stack-fault and denormal exceptions accumulate in sticky bits until a clear strobe removes them. A load strobe presets the empty mask and the top pointer.

Operands use this layout: bit 79 is the sign, bits 78:64 are the exponent, and bits 63:0 are the significand with an explicit integer bit at bit 63.

Top module: `fpcmp_unit`

## Requirements
- R1: The result and the exception bits are registered at the rising edge that samples `start` high. `done` is high for exactly the one cycle after that edge and is low otherwise.
- R2: The compare result is written to `cc` as cc[3]=C3, cc[2]=C2, cc[1]=C1, cc[0]=C0. {C3,C2,C0} is 000 when top > source, 001 when top < source, 100 when they are equal, and 111 when the operands cannot be ordered.
- R3: The comparison is signed. Positive values rank above negative values. -infinity (exponent all ones, fraction zero) ranks below every other value and +infinity ranks above every other value, and neither raises an exception. -0.0 equals +0.0.
- R4: When `unordered`=0, an empty operand register or any NaN gives 111 and sets `excInvalid`. A NaN has an all-ones exponent and a nonzero fraction, where the fraction is bits 62:0.
- R5: When `unordered`=1, a quiet NaN (fraction bit 62 = 1) gives 111 and leaves `excInvalid` clear. A signaling NaN (bit 62 = 0) or an empty operand register gives 111 and sets `excInvalid`.
- R6: `excStack` is set, together with `excInvalid`, when the top register is empty or when a register used as the source is empty.
- R7: A non-empty denormal operand (exponent zero, significand nonzero) sets `excDenorm`, and the compare result is still correct.
- R8: With `flagMode`=1 the result goes to `zf`/`pf`/`cf` with the same pattern as C3/C2/C0, and `cc` is unchanged. With `flagMode`=0 the flags are unchanged.
- R9: Every compare with `flagMode`=0 clears C1.
- R10: `srcSel` chooses the source. 0 selects the register at (top + `regIdx`) mod 8. 1 selects `extOperand`. 2 or 3 selects +0.0, and in that case `extOperand` is ignored.
- R11: `popSel`=1 marks the top register empty and increments the top pointer modulo 8. `popSel`=2 or 3 does this twice and always compares against the register at top+1, ignoring `srcSel` and `regIdx`.
- R12: The exception bits are sticky until `clrExc`. If `clrExc` and a compare fall in the same cycle, the new exceptions of that compare remain set.
- R13: Reset gives top pointer 0, all registers empty, `cc`=0, all flags and exceptions 0, and `done`=0. `loadEn` writes `loadEmpty` and `loadTop` and takes priority over a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a compare |
| srcSel | input | 2 | Source select: register, external, or +0.0 |
| regIdx | input | 3 | Source register offset from the top |
| popSel | input | 2 | 0 no pop, 1 single pop, 2/3 double pop |
| unordered | input | 1 | Selects quiet-NaN-tolerant handling |
| flagMode | input | 1 | Result goes to zf/pf/cf instead of cc |
| extOperand | input | 80 | External source operand |
| regVals | input | 640 | Stack register contents, physical entry k at bits 80k+79:80k |
| clrExc | input | 1 | Clears the sticky exception bits |
| loadEn | input | 1 | Loads the empty mask and the top pointer |
| loadEmpty | input | 8 | Empty mask to load, 1 = empty |
| loadTop | input | 3 | Top pointer to load |
| cc | output | 4 | Condition field {C3,C2,C1,C0} |
| zf | output | 1 | Zero-style flag |
| pf | output | 1 | Parity-style flag |
| cf | output | 1 | Carry-style flag |
| excInvalid | output | 1 | Sticky invalid-operation exception |
| excStack | output | 1 | Sticky stack-fault exception |
| excDenorm | output | 1 | Sticky denormal exception |
| done | output | 1 | One-cycle completion pulse |
| topPtr | output | 3 | Current top pointer |
| emptyMask | output | 8 | Per-register empty flags |

## Verification
The exception clear and a new compare can share a clock edge. The clear would erase the sticky bits while the compare is trying to set them. The bench raises `clrExc` in the same cycle as the start of an ordered compare against a quiet NaN, and then checks that `excInvalid` is set in the following cycle. A separate pulse of `clrExc` alone then checks that the bit drops to zero.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  // Strobes passed from the control block to the datapath
  typedef struct packed {
    logic doCmp;    // capture a compare result this edge
    logic toFlags;  // write zf/pf/cf instead of the condition field
    logic useZero;  // source is the constant +0.0
    logic srcReg;   // source is a stack register
    logic unord;    // quiet NaNs do not raise invalid
    logic clrExc;   // clear the sticky exception bits
  } strobeT;

  localparam logic [1:0] POP_NONE = 2'd0;
  localparam logic [1:0] POP_ONE  = 2'd1;
  localparam logic [1:0] SRC_REG  = 2'd0;

endpackage

// File: rtl/fpcmp_class.sv
module fpcmp_class #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  localparam int VAL_W = 1 + EXP_W + SIG_W
) (
  input  logic [VAL_W-1:0]   val,
  output logic               sign,
  output logic               isNan,
  output logic               isSnan,
  output logic               isZero,
  output logic               isDen,
  output logic [VAL_W-2:0]   mag
);
  logic [EXP_W-1:0] expField;
  logic [SIG_W-1:0] sigField;
  logic             expMax;

  assign sign     = val[VAL_W-1];
  assign expField = val[VAL_W-2 -: EXP_W];
  assign sigField = val[SIG_W-1:0];
  assign expMax   = &expField;

  // fraction excludes the explicit integer bit; its top bit is the quiet bit
  assign isNan  = expMax && (|sigField[SIG_W-2:0]);
  assign isSnan = isNan && !sigField[SIG_W-2];
  assign isZero = (expField == '0) && (sigField == '0);
  assign isDen  = (expField == '0) && (sigField != '0);
  assign mag    = val[VAL_W-2:0];
endmodule

// File: rtl/fpcmp_ctrl.sv
module fpcmp_ctrl
  import fpcmp_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       srcSel,
  input  logic [PTR_W-1:0] regIdx,
  input  logic [1:0]       popSel,
  input  logic             unordered,
  input  logic             flagMode,
  input  logic             clrExc,
  input  logic             loadEn,
  input  logic [DEPTH-1:0] loadEmpty,
  input  logic [PTR_W-1:0] loadTop,
  output strobeT           strb,
  output logic [PTR_W-1:0] srcIdx,
  output logic             emptyTop,
  output logic             emptySrc,
  output logic [PTR_W-1:0] topPtr,
  output logic [DEPTH-1:0] emptyMask
);
  logic             popOne, popTwo, srcIsReg;
  logic [PTR_W-1:0] effIdx, topPlus1, topNext;
  logic [DEPTH-1:0] maskNext;

  assign popOne   = start && (popSel == POP_ONE);
  assign popTwo   = start && popSel[1];
  assign srcIsReg = popTwo || (srcSel == SRC_REG);
  assign effIdx   = popTwo ? PTR_W'(1) : regIdx;
  assign srcIdx   = topPtr + effIdx;
  assign topPlus1 = topPtr + PTR_W'(1);
  assign emptyTop = emptyMask[topPtr];
  assign emptySrc = srcIsReg && emptyMask[srcIdx];

  always_comb begin
    strb         = '0;
    strb.doCmp   = start;
    strb.toFlags = flagMode;
    strb.useZero = !srcIsReg && srcSel[1];
    strb.srcReg  = srcIsReg;
    strb.unord   = unordered;
    strb.clrExc  = clrExc;
  end

  always_comb begin
    maskNext = emptyMask;
    topNext  = topPtr;
    if (loadEn) begin
      maskNext = loadEmpty;
      topNext  = loadTop;
    end else if (popOne) begin
      maskNext[topPtr] = 1'b1;
      topNext          = topPlus1;
    end else if (popTwo) begin
      maskNext[topPtr]   = 1'b1;
      maskNext[topPlus1] = 1'b1;
      topNext            = topPtr + PTR_W'(2);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topPtr    <= '0;
      emptyMask <= '1;
    end else begin
      topPtr    <= topNext;
      emptyMask <= maskNext;
    end
  end

  // R11: a single pop advances the pointer by one and empties the old top
  p_pop_one_r11: assert property (@(posedge clk) disable iff (!rstN)
    (popOne && !loadEn) |=> (topPtr == PTR_W'($past(topPtr) + 1)) && emptyMask[$past(topPtr)]);

  // R11: a double pop advances the pointer by two
  p_pop_two_r11: assert property (@(posedge clk) disable iff (!rstN)
    (popTwo && !loadEn) |=> topPtr == PTR_W'($past(topPtr) + 2));

  // R11: without start or load, the stack state holds
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !loadEn) |=> $stable(topPtr) && $stable(emptyMask));

  // R13: a load overrides any pop in the same cycle
  p_load_wins_r13: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (topPtr == $past(loadTop)) && (emptyMask == $past(loadEmpty)));
endmodule

// File: rtl/fpcmp_dp.sv
module fpcmp_dp
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int VAL_W = 1 + EXP_W + SIG_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobeT                 strb,
  input  logic [DEPTH*VAL_W-1:0] regVals,
  input  logic [VAL_W-1:0]       extOperand,
  input  logic [PTR_W-1:0]       topIdx,
  input  logic [PTR_W-1:0]       srcIdx,
  input  logic                   emptyTop,
  input  logic                   emptySrc,
  output logic [3:0]             cc,
  output logic                   zf,
  output logic                   pf,
  output logic                   cf,
  output logic                   excInvalid,
  output logic                   excStack,
  output logic                   excDenorm,
  output logic                   done
);
  logic [VAL_W-1:0] regArr [DEPTH];
  logic [VAL_W-1:0] opnd   [2];
  logic             sgn [2], nan [2], snan [2], zer [2], den [2];
  logic [VAL_W-2:0] mag [2];

  for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
    assign regArr[g] = regVals[g*VAL_W +: VAL_W];
  end

  assign opnd[0] = regArr[topIdx];
  assign opnd[1] = strb.useZero ? '0 : (strb.srcReg ? regArr[srcIdx] : extOperand);

  for (genvar k = 0; k < 2; k++) begin : g_class
    fpcmp_class #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_class (
      .val(opnd[k]), .sign(sgn[k]), .isNan(nan[k]), .isSnan(snan[k]),
      .isZero(zer[k]), .isDen(den[k]), .mag(mag[k]));
  end

  logic       anyEmpty, unordRes, magGt, magEq;
  logic [2:0] res;
  logic       invNew, stkNew, denNew;

  assign anyEmpty = emptyTop || emptySrc;
  assign unordRes = anyEmpty || nan[0] || nan[1];
  assign magGt    = mag[0] > mag[1];
  assign magEq    = mag[0] == mag[1];

  always_comb begin
    if (unordRes)                              res = 3'b111;
    else if ((zer[0] && zer[1]) || (sgn[0] == sgn[1] && magEq))
                                               res = 3'b100;
    else if (sgn[0] != sgn[1])                 res = sgn[0] ? 3'b001 : 3'b000;
    else if (sgn[0] ? !magGt : magGt)          res = 3'b000;
    else                                       res = 3'b001;
  end

  assign invNew = anyEmpty || (strb.unord ? (snan[0] || snan[1]) : (nan[0] || nan[1]));
  assign stkNew = anyEmpty;
  assign denNew = (den[0] && !emptyTop) || (den[1] && !emptySrc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cc <= '0;
      {zf, pf, cf} <= '0;
      {excInvalid, excStack, excDenorm} <= '0;
      done <= 1'b0;
    end else begin
      done <= strb.doCmp;
      if (strb.doCmp) begin
        if (strb.toFlags) {zf, pf, cf} <= res;
        else              cc <= {res[2], res[1], 1'b0, res[0]};
      end
      excInvalid <= (excInvalid && !strb.clrExc) || (strb.doCmp && invNew);
      excStack   <= (excStack   && !strb.clrExc) || (strb.doCmp && stkNew);
      excDenorm  <= (excDenorm  && !strb.clrExc) || (strb.doCmp && denNew);
    end
  end

  // R1: done follows a start by exactly one cycle
  p_done_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.doCmp |=> done);
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doCmp |=> !done);

  // R2: C2 only ever appears in the unordered code
  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doCmp && !strb.toFlags) |=> (!cc[2] || (cc[3] && cc[0])));

  // R6: an empty operand register raises stack fault and invalid
  p_stack_fault_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doCmp && anyEmpty) |=> excStack && excInvalid);

  // R8: flag mode leaves the condition field, code mode leaves the flags
  p_flag_keeps_cc_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doCmp && strb.toFlags) |=> $stable(cc));
  p_cc_keeps_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doCmp && !strb.toFlags) |=> $stable({zf, pf, cf}));

  // R9: C1 cleared by a condition-code compare
  p_c1_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doCmp && !strb.toFlags) |=> !cc[1]);

  // R12: exceptions only fall after a clear
  p_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrExc |=> !$fell(excInvalid) && !$fell(excStack) && !$fell(excDenorm));
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int VAL_W = 1 + EXP_W + SIG_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [1:0]             srcSel,
  input  logic [PTR_W-1:0]       regIdx,
  input  logic [1:0]             popSel,
  input  logic                   unordered,
  input  logic                   flagMode,
  input  logic [VAL_W-1:0]       extOperand,
  input  logic [DEPTH*VAL_W-1:0] regVals,
  input  logic                   clrExc,
  input  logic                   loadEn,
  input  logic [DEPTH-1:0]       loadEmpty,
  input  logic [PTR_W-1:0]       loadTop,
  output logic [3:0]             cc,
  output logic                   zf,
  output logic                   pf,
  output logic                   cf,
  output logic                   excInvalid,
  output logic                   excStack,
  output logic                   excDenorm,
  output logic                   done,
  output logic [PTR_W-1:0]       topPtr,
  output logic [DEPTH-1:0]       emptyMask
);
  strobeT           strb;
  logic [PTR_W-1:0] srcIdx;
  logic             emptyTop, emptySrc;

  fpcmp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .srcSel(srcSel), .regIdx(regIdx),
    .popSel(popSel), .unordered(unordered), .flagMode(flagMode), .clrExc(clrExc),
    .loadEn(loadEn), .loadEmpty(loadEmpty), .loadTop(loadTop), .strb(strb),
    .srcIdx(srcIdx), .emptyTop(emptyTop), .emptySrc(emptySrc),
    .topPtr(topPtr), .emptyMask(emptyMask));

  fpcmp_dp #(.EXP_W(EXP_W), .SIG_W(SIG_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regVals(regVals), .extOperand(extOperand),
    .topIdx(topPtr), .srcIdx(srcIdx), .emptyTop(emptyTop), .emptySrc(emptySrc),
    .cc(cc), .zf(zf), .pf(pf), .cf(cf), .excInvalid(excInvalid),
    .excStack(excStack), .excDenorm(excDenorm), .done(done));
endmodule

// File: tb/fpcmp_unit_bench.sv
`timescale 1ns/1ps
module fpcmp_unit_bench;
  localparam logic [79:0] ONE    = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] TWO    = {1'b0, 15'h4000, 64'h8000_0000_0000_0000};
  localparam logic [79:0] NONE   = {1'b1, 15'h3FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] NBIG   = {1'b1, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [79:0] PZERO  = 80'h0;
  localparam logic [79:0] NZERO  = {1'b1, 79'h0};
  localparam logic [79:0] PINF   = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] NINF   = {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] QNAN   = {1'b0, 15'h7FFF, 64'hC000_0000_0000_0000};
  localparam logic [79:0] SNAN   = {1'b0, 15'h7FFF, 64'hA000_0000_0000_0000};
  localparam logic [79:0] DEN1   = {1'b0, 15'h0000, 64'h0000_0000_0000_0001};
  localparam logic [79:0] DEN2   = {1'b0, 15'h0000, 64'h0000_0000_0000_0002};

  typedef struct packed {
    logic [79:0] a;
    logic [79:0] b;
    logic        unord;
    logic [2:0]  code;   // {C3,C2,C0}
    logic        inv;
    logic        den;
  } vecT;

  localparam int NVEC = 14;
  localparam vecT VECS [NVEC] = '{
    '{ONE,   TWO,   1'b0, 3'b001, 1'b0, 1'b0},  // R2 less
    '{TWO,   ONE,   1'b0, 3'b000, 1'b0, 1'b0},  // R2 greater
    '{ONE,   ONE,   1'b0, 3'b100, 1'b0, 1'b0},  // R2 equal
    '{NONE,  ONE,   1'b0, 3'b001, 1'b0, 1'b0},  // R3 sign
    '{NONE,  NBIG,  1'b0, 3'b000, 1'b0, 1'b0},  // R3 negative magnitudes
    '{PZERO, NZERO, 1'b0, 3'b100, 1'b0, 1'b0},  // R3 signed zeros
    '{NINF,  NBIG,  1'b0, 3'b001, 1'b0, 1'b0},  // R3 -inf lowest
    '{PINF,  TWO,   1'b0, 3'b000, 1'b0, 1'b0},  // R3 +inf highest
    '{QNAN,  ONE,   1'b0, 3'b111, 1'b1, 1'b0},  // R4 ordered qnan
    '{QNAN,  ONE,   1'b1, 3'b111, 1'b0, 1'b0},  // R5 unordered qnan
    '{ONE,   SNAN,  1'b1, 3'b111, 1'b1, 1'b0},  // R5 unordered snan
    '{DEN1,  PZERO, 1'b0, 3'b000, 1'b0, 1'b1},  // R7 denormal vs zero
    '{DEN1,  DEN2,  1'b0, 3'b001, 1'b0, 1'b1},  // R7 two denormals
    '{NONE,  DEN1,  1'b0, 3'b001, 1'b0, 1'b1}   // R7 negative vs denormal
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   srcSel = 2'd1;
  logic [2:0]   regIdx = 3'd0;
  logic [1:0]   popSel = 2'd0;
  logic         unordered = 1'b0;
  logic         flagMode = 1'b0;
  logic [79:0]  extOperand = '0;
  logic [639:0] regVals = '0;
  logic         clrExc = 1'b0;
  logic         loadEn = 1'b0;
  logic [7:0]   loadEmpty = '0;
  logic [2:0]   loadTop = '0;
  logic [3:0]   cc;
  logic         zf, pf, cf, excInvalid, excStack, excDenorm, done;
  logic [2:0]   topPtr;
  logic [7:0]   emptyMask;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fpcmp_unit u_fpcmp_unit (
    .clk(clk), .rstN(rstN), .start(start), .srcSel(srcSel), .regIdx(regIdx),
    .popSel(popSel), .unordered(unordered), .flagMode(flagMode),
    .extOperand(extOperand), .regVals(regVals), .clrExc(clrExc), .loadEn(loadEn),
    .loadEmpty(loadEmpty), .loadTop(loadTop), .cc(cc), .zf(zf), .pf(pf), .cf(cf),
    .excInvalid(excInvalid), .excStack(excStack), .excDenorm(excDenorm),
    .done(done), .topPtr(topPtr), .emptyMask(emptyMask));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic setReg(input int idx, input logic [79:0] v);
    regVals[idx*80 +: 80] = v;
  endtask

  task automatic loadStack(input logic [7:0] mask, input logic [2:0] top);
    @(negedge clk);
    loadEn = 1'b1; loadEmpty = mask; loadTop = top;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk);
    clrExc = 1'b1;
    @(negedge clk);
    clrExc = 1'b0;
  endtask

  // drives one compare; returns at the negedge after the capturing edge
  task automatic runCmp(input logic [1:0] sel, input logic [2:0] idx, input logic [1:0] pop,
                        input logic unord, input logic flag, input logic clr);
    @(negedge clk);
    srcSel = sel; regIdx = idx; popSel = pop; unordered = unord; flagMode = flag;
    clrExc = clr; start = 1'b1;
    @(negedge clk);
    start = 1'b0; clrExc = 1'b0; popSel = 2'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 reset cc", cc, 0);
    check("R13 reset flags", {zf, pf, cf, excInvalid, excStack, excDenorm, done}, 0);
    check("R13 reset top", topPtr, 0);
    check("R13 reset empty", emptyMask, 8'hFF);
    rstN = 1'b1;

    // R13 load
    loadStack(8'h00, 3'd0);
    check("R13 load empty", emptyMask, 8'h00);

    // vector table, external source
    for (int i = 0; i < NVEC; i++) begin
      pulseClr();
      setReg(0, VECS[i].a);
      extOperand = VECS[i].b;
      runCmp(2'd1, 3'd0, 2'd0, VECS[i].unord, 1'b0, 1'b0);
      check($sformatf("R1 done vec%0d", i), done, 1);
      check($sformatf("R2 R3 code vec%0d", i), {cc[3], cc[2], cc[0]}, VECS[i].code);
      check($sformatf("R9 C1 vec%0d", i), cc[1], 0);
      check($sformatf("R4 R5 invalid vec%0d", i), excInvalid, VECS[i].inv);
      check($sformatf("R7 denormal vec%0d", i), excDenorm, VECS[i].den);
      check($sformatf("R6 no stack vec%0d", i), excStack, 0);
    end
    @(negedge clk);
    check("R1 done drops", done, 0);

    // R4 R6 empty top
    pulseClr();
    loadStack(8'hFF, 3'd0);
    setReg(0, ONE); extOperand = ONE;
    runCmp(2'd1, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R4 empty top code", {cc[3], cc[2], cc[0]}, 3'b111);
    check("R6 empty top stack", {excStack, excInvalid}, 2'b11);

    // R5 R6 empty source register, unordered variant
    pulseClr();
    check("R12 clear alone", {excInvalid, excStack, excDenorm}, 0);
    loadStack(8'h01, 3'd5);
    setReg(5, ONE); setReg(0, ONE);
    runCmp(2'd0, 3'd3, 2'd0, 1'b1, 1'b0, 1'b0);
    check("R6 empty src code", {cc[3], cc[2], cc[0]}, 3'b111);
    check("R5 R6 empty src exc", {excStack, excInvalid}, 2'b11);

    // R10 register source, non-empty
    pulseClr();
    loadStack(8'h00, 3'd5);
    setReg(5, ONE); setReg(0, TWO); extOperand = QNAN;
    runCmp(2'd0, 3'd3, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R10 register source", {cc[3], cc[2], cc[0], excInvalid}, 4'b0010);

    // R8 flag mode
    setReg(5, ONE); extOperand = TWO;
    runCmp(2'd1, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R8 setup cc", cc, 4'b0001);
    setReg(5, TWO); extOperand = ONE;
    runCmp(2'd1, 3'd0, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R8 flags greater", {zf, pf, cf}, 3'b000);
    check("R8 cc kept", cc, 4'b0001);
    setReg(5, ONE);
    runCmp(2'd1, 3'd0, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R8 flags equal", {zf, pf, cf}, 3'b100);
    setReg(5, QNAN);
    runCmp(2'd1, 3'd0, 2'd0, 1'b1, 1'b1, 1'b0);
    check("R8 flags unordered", {zf, pf, cf}, 3'b111);
    check("R8 cc still kept", cc, 4'b0001);
    setReg(5, NONE);
    runCmp(2'd1, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R8 code mode keeps flags", {zf, pf, cf}, 3'b111);

    // R10 zero source, external ignored
    extOperand = NBIG;
    setReg(5, NZERO);
    runCmp(2'd2, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R10 zero source neg zero", {cc[3], cc[2], cc[0]}, 3'b100);
    setReg(5, NONE);
    runCmp(2'd3, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R10 zero source negative", {cc[3], cc[2], cc[0]}, 3'b001);

    // R11 single pop
    loadStack(8'h00, 3'd6);
    setReg(6, ONE); setReg(0, TWO);
    runCmp(2'd0, 3'd2, 2'd1, 1'b0, 1'b0, 1'b0);
    check("R11 single pop code", {cc[3], cc[2], cc[0]}, 3'b001);
    check("R11 single pop top", topPtr, 3'd7);
    check("R11 single pop empty", emptyMask, 8'h40);

    // R11 double pop, source forced to top+1
    pulseClr();
    loadStack(8'h00, 3'd7);
    setReg(7, TWO); setReg(0, ONE); setReg(4, QNAN); extOperand = QNAN;
    runCmp(2'd1, 3'd5, 2'd2, 1'b0, 1'b0, 1'b0);
    check("R11 double pop code", {cc[3], cc[2], cc[0], excInvalid}, 4'b0000);
    check("R11 double pop top", topPtr, 3'd1);
    check("R11 double pop empty", emptyMask, 8'h81);

    // R12 stickiness and clear/compare collision
    loadStack(8'h00, 3'd0);
    setReg(0, QNAN); extOperand = ONE;
    runCmp(2'd1, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    setReg(0, TWO);
    runCmp(2'd1, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R12 invalid sticky", excInvalid, 1);
    setReg(0, QNAN);
    runCmp(2'd1, 3'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R12 clear with compare keeps new", excInvalid, 1);
    pulseClr();
    check("R12 clear drops", excInvalid, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule